// File: doc/BRIEF.md
# Translation Table Base Selector

This block holds the translation control word and the two first-level table base words of a short-descriptor page-table walker. For every virtual address presented on its lookup port it works out the physical address of the first-level descriptor. Before it does so it picks which base word governs that address and checks whether walks through that base have been switched off. Fetching the descriptor from memory, second-level walks, permission checks and long-descriptor walks are done elsewhere.

Software writes reach the three registers through a simple write port and read them back through a registered read port. A write to the control word is filtered according to three static feature straps: v8 behaviour, the large physical address extension and the security extension. The table-size field N, held in bits [2:0], sets the split between the two bases. Two masks derived from N are recomputed on every control write and kept in registers, so the lookup path only does an AND, an OR and a compare.

Top module: `ttb_selector`

## Requirements
- R1: After synchronous reset the control word and both base words read as 0x00000000, and `lk_valid` is low.
- R2: With `strap_v8`=1, a control write (`wr_sel`=0) stores the written word unchanged.
- R3: With `strap_v8`=0, `strap_lpae`=1 and written bit 31 (extended-address enable) set, bits [21:19], [15:14] and [6:3] are cleared and all other bits are stored.
- R4: With `strap_v8`=0 and the R3 case not applying, the control word keeps only bits [2:0] (N), bit 4 (walk disable for base 0) and bit 5 (walk disable for base 1) when `strap_sec`=1, and only bits [2:0] when `strap_sec`=0.
- R5: Writes to base 0 (`wr_sel`=1) and base 1 (`wr_sel`=2) are stored unmasked; a write takes effect at the clock edge where `wr_en` is sampled, and `rd_data` shows the register picked by `rd_sel` one clock after it is sampled.
- R6: The lookup uses base 1 (`lk_base_id`=1) when the address has a set bit among its top N bits, and uses base 0 otherwise; with N=0 base 0 is always used.
- R7: The descriptor address is the selected base ANDed with 0xFFFFC000 for base 1, or with 0xFFFFC000 shifted right by N for base 0, then ORed with bits [31:20] of the address placed at bits [13:2].
- R8: When the selected base has its walk-disable bit set (bit 4 for base 0, bit 5 for base 1), the response has `lk_fault`=1, `lk_fault_code`=5 (section translation fault) and `lk_addr`=0; otherwise `lk_fault`=0 and `lk_fault_code`=0.
- R9: `lk_valid` is `lk_req` delayed by one clock, and the response is computed from the register values held before any write sampled at the same edge as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_v8 | input | 1 | v8 behaviour: control writes stored unmasked |
| strap_lpae | input | 1 | Large physical address extension present |
| strap_sec | input | 1 | Security extension present |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 base 0, 2 base 1 |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | 32 | Registered read data |
| lk_req | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address for the lookup |
| lk_valid | output | 1 | Lookup response strobe |
| lk_addr | output | 32 | First-level descriptor address, 0 on fault |
| lk_base_id | output | 1 | Base used: 0 or 1 |
| lk_fault | output | 1 | Walk disabled for the selected base |
| lk_fault_code | output | 4 | Fault code, 5 when `lk_fault` is set |

## Verification
The bench goes after the filter's priority order. A design that tested the security strap before the extended-address case would drop the upper fields of a large-address write. A design that ignored the v8 strap would clear bits that must survive. At the lookup it drives addresses just below and at the split for N=7. An off-by-one in the selection mask would send those addresses to the wrong base, and a base-0 mask not shifted by N would leave stray low base bits in the address. Requests issued in the same cycle as a control write that sets a walk-disable bit catch a design that lets the new value leak into the response.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int XW        = 32;
  localparam int NW        = 3;
  localparam int FCW       = 4;
  localparam int PD0_BIT   = 4;
  localparam int PD1_BIT   = 5;
  localparam int EAE_BIT   = 31;
  localparam int ALIGN_LSB = 14;
  localparam int IDX_SHIFT = 18;
  localparam int NUM_BASE  = 2;

  localparam logic [XW-1:0] LPAE_CLEAR = 32'h0038_C078;
  localparam logic [XW-1:0] SEC_KEEP   = 32'h0000_0037;
  localparam logic [XW-1:0] PLAIN_KEEP = 32'h0000_0007;
  localparam logic [XW-1:0] ALIGN_MASK = 32'hFFFF_C000;
  localparam logic [XW-1:0] IDX_MASK   = 32'h0000_3FFC;
  localparam logic [FCW-1:0] FC_SECTION = 4'd5;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE0 = 2'd1,
    SEL_BASE1 = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [XW-1:0]  addr;
    logic           base_id;
    logic           fault;
    logic [FCW-1:0] code;
  } lk_resp_t;
endpackage

// File: rtl/ttb_ctrl_filter.sv
module ttb_ctrl_filter
  import ttb_pkg::*;
(
  input  logic          strap_v8,
  input  logic          strap_lpae,
  input  logic          strap_sec,
  input  logic [XW-1:0] din,
  output logic [XW-1:0] dout
);
  always_comb begin
    if (strap_v8) begin
      dout = din;
    end else if (strap_lpae && din[EAE_BIT]) begin
      dout = din & ~LPAE_CLEAR;
    end else if (strap_sec) begin
      dout = din & SEC_KEEP;
    end else begin
      dout = din & PLAIN_KEEP;
    end
  end
endmodule

// File: rtl/ttb_mask_gen.sv
module ttb_mask_gen
  import ttb_pkg::*;
(
  input  logic [NW-1:0] n,
  output logic [XW-1:0] sel_mask,
  output logic [XW-1:0] b0_mask
);
  localparam logic [XW-1:0] ALL_ONES = {XW{1'b1}};

  always_comb begin
    if (n == '0) begin
      sel_mask = '0;
    end else begin
      sel_mask = ~(ALL_ONES >> n);
    end
    b0_mask = ALIGN_MASK >> n;
  end
endmodule

// File: rtl/ttb_regs.sv
module ttb_regs
  import ttb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [XW-1:0] ctrl_next,
  input  logic [XW-1:0] sel_mask_next,
  input  logic [XW-1:0] b0_mask_next,
  input  logic [XW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [XW-1:0] rd_data,
  output logic [XW-1:0] ctrl_q,
  output logic [XW-1:0] sel_mask_q,
  output logic [XW-1:0] b0_mask_q,
  output logic [XW-1:0] base_q [NUM_BASE]
);
  logic ctrl_we;
  assign ctrl_we = wr_en && (wr_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      sel_mask_q <= '0;
      b0_mask_q  <= ALIGN_MASK;
    end else if (ctrl_we) begin
      ctrl_q     <= ctrl_next;
      sel_mask_q <= sel_mask_next;
      b0_mask_q  <= b0_mask_next;
    end
  end

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    localparam logic [1:0] MY_SEL = 2'(g + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
      end else if (wr_en && (wr_sel == MY_SEL)) begin
        base_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_sel)
        SEL_CTRL:  rd_data <= ctrl_q;
        SEL_BASE0: rd_data <= base_q[0];
        SEL_BASE1: rd_data <= base_q[1];
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ttb_lookup.sv
module ttb_lookup
  import ttb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [XW-1:0] va,
  input  logic [XW-1:0] ctrl_q,
  input  logic [XW-1:0] sel_mask_q,
  input  logic [XW-1:0] b0_mask_q,
  input  logic [XW-1:0] base0_q,
  input  logic [XW-1:0] base1_q,
  output logic          valid,
  output lk_resp_t      resp
);
  logic          use_b1;
  logic          walk_off;
  logic [XW-1:0] base_sel;
  logic [XW-1:0] idx;
  lk_resp_t      resp_d;

  always_comb begin
    use_b1   = |(va & sel_mask_q);
    base_sel = use_b1 ? (base1_q & ALIGN_MASK) : (base0_q & b0_mask_q);
    idx      = (va >> IDX_SHIFT) & IDX_MASK;
    walk_off = use_b1 ? ctrl_q[PD1_BIT] : ctrl_q[PD0_BIT];
    resp_d.base_id = use_b1;
    resp_d.fault   = walk_off;
    resp_d.code    = walk_off ? FC_SECTION : '0;
    resp_d.addr    = walk_off ? '0 : (base_sel | idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      resp  <= '0;
    end else begin
      valid <= req;
      if (req) begin
        resp <= resp_d;
      end
    end
  end
endmodule

// File: rtl/ttb_selector.sv
module ttb_selector
  import ttb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_v8,
  input  logic          strap_lpae,
  input  logic          strap_sec,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic [1:0]    rd_sel,
  output logic [31:0]   rd_data,
  input  logic          lk_req,
  input  logic [31:0]   lk_va,
  output logic          lk_valid,
  output logic [31:0]   lk_addr,
  output logic          lk_base_id,
  output logic          lk_fault,
  output logic [3:0]    lk_fault_code
);
  logic [XW-1:0] ctrl_next;
  logic [XW-1:0] sel_mask_next;
  logic [XW-1:0] b0_mask_next;
  logic [XW-1:0] ctrl_q;
  logic [XW-1:0] sel_mask_q;
  logic [XW-1:0] b0_mask_q;
  logic [XW-1:0] base_q [NUM_BASE];
  logic [XW-1:0] base0_q;
  logic [XW-1:0] base1_q;
  lk_resp_t      resp;

  ttb_ctrl_filter u_filter (
    .strap_v8  (strap_v8),
    .strap_lpae(strap_lpae),
    .strap_sec (strap_sec),
    .din       (wr_data),
    .dout      (ctrl_next)
  );

  ttb_mask_gen u_masks (
    .n       (ctrl_next[NW-1:0]),
    .sel_mask(sel_mask_next),
    .b0_mask (b0_mask_next)
  );

  ttb_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .ctrl_next    (ctrl_next),
    .sel_mask_next(sel_mask_next),
    .b0_mask_next (b0_mask_next),
    .wr_data      (wr_data),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .ctrl_q       (ctrl_q),
    .sel_mask_q   (sel_mask_q),
    .b0_mask_q    (b0_mask_q),
    .base_q       (base_q)
  );

  assign base0_q = base_q[0];
  assign base1_q = base_q[1];

  ttb_lookup u_lookup (
    .clk       (clk),
    .rst       (rst),
    .req       (lk_req),
    .va        (lk_va),
    .ctrl_q    (ctrl_q),
    .sel_mask_q(sel_mask_q),
    .b0_mask_q (b0_mask_q),
    .base0_q   (base0_q),
    .base1_q   (base1_q),
    .valid     (lk_valid),
    .resp      (resp)
  );

  assign lk_addr       = resp.addr;
  assign lk_base_id    = resp.base_id;
  assign lk_fault      = resp.fault;
  assign lk_fault_code = resp.code;
endmodule

// File: rtl/ttb_selector_chk.sv
module ttb_selector_chk
  import ttb_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          strap_v8,
  input logic          strap_lpae,
  input logic          strap_sec,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [31:0]   wr_data,
  input logic          lk_req,
  input logic          lk_valid,
  input logic [31:0]   lk_addr,
  input logic          lk_base_id,
  input logic          lk_fault,
  input logic [3:0]    lk_fault_code,
  input logic [31:0]   ctrl_q,
  input logic [31:0]   base1_q
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

  // R2
  v8_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && strap_v8) |=> (ctrl_q == $past(wr_data)));

  // R3
  eae_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !strap_v8 && strap_lpae && wr_data[EAE_BIT])
      |=> (((ctrl_q & LPAE_CLEAR) == '0) && ctrl_q[EAE_BIT]));

  // R4
  short_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !strap_v8 && !(strap_lpae && wr_data[EAE_BIT]))
      |=> ((ctrl_q[31:6] == '0) && (ctrl_q[3] == 1'b0)));

  // R6
  base1_align_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_fault && lk_base_id)
      |-> (lk_addr[31:ALIGN_LSB] == $past(base1_q[31:ALIGN_LSB])));

  // R8
  fault_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_fault) |-> ((lk_addr == '0) && (lk_fault_code == FC_SECTION)));

  // R8
  no_fault_code_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_fault) |-> (lk_fault_code == '0));

  // R9
  req_echo_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid);

  // R9
  idle_echo_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_valid);
endmodule

bind ttb_selector ttb_selector_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .strap_v8     (strap_v8),
  .strap_lpae   (strap_lpae),
  .strap_sec    (strap_sec),
  .wr_en        (wr_en),
  .wr_sel       (wr_sel),
  .wr_data      (wr_data),
  .lk_req       (lk_req),
  .lk_valid     (lk_valid),
  .lk_addr      (lk_addr),
  .lk_base_id   (lk_base_id),
  .lk_fault     (lk_fault),
  .lk_fault_code(lk_fault_code),
  .ctrl_q       (ctrl_q),
  .base1_q      (base1_q)
);

// File: tb/ttb_selector_test.sv
`timescale 1ns/1ps
module ttb_selector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_v8 = 1'b0, strap_lpae = 1'b0, strap_sec = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        lk_base_id;
  logic        lk_fault;
  logic [3:0]  lk_fault_code;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ttb_selector uut (
    .clk(clk), .rst(rst),
    .strap_v8(strap_v8), .strap_lpae(strap_lpae), .strap_sec(strap_sec),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .lk_req(lk_req), .lk_va(lk_va), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .lk_base_id(lk_base_id),
    .lk_fault(lk_fault), .lk_fault_code(lk_fault_code)
  );

  // {v8, lpae, sec, written word, expected stored word}
  localparam logic [66:0] WVEC [8] = '{
    {3'b000, 32'hFFFF_FFFF, 32'h0000_0007},
    {3'b001, 32'hFFFF_FFFF, 32'h0000_0037},
    {3'b010, 32'hFFFF_FFFF, 32'hFFC7_3F87},
    {3'b010, 32'h7FFF_FFFF, 32'h0000_0007},
    {3'b011, 32'h7FFF_FFFF, 32'h0000_0037},
    {3'b100, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {3'b011, 32'h8000_0078, 32'h8000_0000},
    {3'b001, 32'h8000_0010, 32'h0000_0010}
  };

  // base0 = ABCDEFFF, base1 = 55557777, security strap on
  // {control word, va, expected addr, expected base id, expected fault}
  localparam logic [97:0] LVEC [9] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hABCD_FFFC, 1'b0, 1'b0},
    {32'h0000_0001, 32'h8000_0000, 32'h5555_6000, 1'b1, 1'b0},
    {32'h0000_0001, 32'h7FFF_FFFF, 32'h2BCD_FFFC, 1'b0, 1'b0},
    {32'h0000_0007, 32'h01FF_FFFF, 32'h01CD_EFFC, 1'b0, 1'b0},
    {32'h0000_0007, 32'h0200_0000, 32'h5555_4080, 1'b1, 1'b0},
    {32'h0000_0017, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1},
    {32'h0000_0017, 32'hFFFF_FFFF, 32'h5555_7FFC, 1'b1, 1'b0},
    {32'h0000_0027, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1},
    {32'h0000_0010, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] data);
    rd_sel = sel;
    @(negedge clk);
    data = rd_data;
  endtask

  task automatic lookup(input logic [31:0] va);
    lk_req = 1'b1; lk_va = va;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(lk_valid == 1'b0, "R1 lk_valid after reset", {31'b0, lk_valid}, 32'h0);
    reg_read(2'd0, rv);
    check(rv == 32'h0, "R1 control reset", rv, 32'h0);
    reg_read(2'd1, rv);
    check(rv == 32'h0, "R1 base0 reset", rv, 32'h0);
    reg_read(2'd2, rv);
    check(rv == 32'h0, "R1 base1 reset", rv, 32'h0);

    // R2 R3 R4 control filtering table
    for (int i = 0; i < 8; i++) begin
      logic [31:0] exp;
      string tag;
      {strap_v8, strap_lpae, strap_sec} = WVEC[i][66:64];
      exp = WVEC[i][31:0];
      if (strap_v8) tag = "R2 v8 write";
      else if (strap_lpae && WVEC[i][63]) tag = "R3 extended write";
      else tag = "R4 short write";
      reg_write(2'd0, WVEC[i][63:32]);
      reg_read(2'd0, rv);
      check(rv == exp, tag, rv, exp);
    end

    // R5 base words unmasked
    strap_v8 = 1'b0; strap_lpae = 1'b0; strap_sec = 1'b1;
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, rv);
    check(rv == 32'hFFFF_FFFF, "R5 base0 unmasked", rv, 32'hFFFF_FFFF);
    reg_write(2'd2, 32'h0000_3FFF);
    reg_read(2'd2, rv);
    check(rv == 32'h0000_3FFF, "R5 base1 unmasked", rv, 32'h0000_3FFF);

    // R6 R7 R8 lookup table
    reg_write(2'd1, 32'hABCD_EFFF);
    reg_write(2'd2, 32'h5555_7777);
    for (int i = 0; i < 9; i++) begin
      reg_write(2'd0, LVEC[i][97:66]);
      lookup(LVEC[i][65:34]);
      check(lk_valid == 1'b1, "R9 response strobe", {31'b0, lk_valid}, 32'h1);
      check(lk_base_id == LVEC[i][1], "R6 base select", {31'b0, lk_base_id},
            {31'b0, LVEC[i][1]});
      check(lk_addr == LVEC[i][33:2], "R7 descriptor address", lk_addr, LVEC[i][33:2]);
      check(lk_fault == LVEC[i][0], "R8 fault flag", {31'b0, lk_fault},
            {31'b0, LVEC[i][0]});
      check(lk_fault_code == (LVEC[i][0] ? 4'd5 : 4'd0), "R8 fault code",
            {28'b0, lk_fault_code}, LVEC[i][0] ? 32'h5 : 32'h0);
    end

    // R9 no request, no strobe
    @(negedge clk);
    check(lk_valid == 1'b0, "R9 idle strobe", {31'b0, lk_valid}, 32'h0);

    // R9 same-edge write does not affect the response
    reg_write(2'd0, 32'h0000_0007);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0000_0027;
    lk_req = 1'b1; lk_va = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    check(lk_fault == 1'b0, "R9 old control used", {31'b0, lk_fault}, 32'h0);
    check(lk_addr == 32'h5555_7FFC, "R9 old control address", lk_addr, 32'h5555_7FFC);
    lookup(32'hFFFF_FFFF);
    check(lk_fault == 1'b1, "R9 new control next request", {31'b0, lk_fault}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule